// File: doc/BRIEF.md
# Serial Port Bit Clock and Frame Pulse Generator

This block produces the bit-clock tick and the frame pulse for a buffered serial port. It also produces the transmit frame pulse. All three outputs are one-cycle or level signals in the system clock domain, so the rest of the port never needs a second clock. A single 32-bit control word sets the behaviour:

- **Clock source:** the system clock, or an external clock pin. The external pin is synchronised and can be counted on either its rising or its falling edges.
- **Division:** the chosen source is divided by a programmable ratio.
- **Frame length and width:** both are counted in bit-clock periods.

In external mode the frame pulse can also be slaved to an incoming receive frame pulse. In that case the programmed frame length is not used: each receive frame edge restarts the divider and the frame count.

The transmit frame output is driven by one of two sources. It either mirrors the generated frame pulse, or it pulses once after each transmit buffer-to-shift-register load.

Top module: `smpl_rate_gen`

## Requirements
- R1: After reset the control word is 0x2000_0001. The block runs from the system clock with a divide ratio of 2. The frame pulse is high on every bit-clock tick. The transmit frame output follows load strobes. While reset is held, all outputs are 0.
- R2: The control word fields are:
  - bit 31: resync enable
  - bit 30: falling-edge select
  - bit 29: internal-source select
  - bit 28: transmit frame from generator
  - bits 27:16: frame period minus one (P)
  - bits 15:8: frame width minus one (W)
  - bits 7:0: divide value minus one (D)
- R3: With bit 29 set, `bclk_en` is a one-cycle pulse every D+1 system clocks. The first pulse comes D+1 cycles after the write edge. `ext_clk` has no effect in this mode.
- R4: With bit 29 clear and bit 30 clear, `bclk_en` pulses once per D+1 rising edges of `ext_clk`. The first pulse appears 3 cycles after the first rising edge that follows a write (for D=0).
- R5: With bit 29 clear and bit 30 set, falling edges of `ext_clk` are counted instead, with the same 3-cycle latency.
- R6: `fsg` changes only together with a `bclk_en` pulse, or on a write. For tick k after a write (k counted from 0), `fsg` is 1 when (k mod (P+1)) ≤ W.
- R7: With bits 29 clear and 31 set, `fsg` stays 0 until a rising edge of `rx_frame` is seen. That edge clears the divider and the frame count. The next tick then starts a frame of W+1 ticks, and P is ignored.
- R8: With bit 31 clear, `rx_frame` has no effect on `bclk_en` or `fsg`.
- R9: With bit 28 clear, `tx_fsync` is high exactly in the cycle after each cycle in which `tx_load` is high, and is 0 otherwise.
- R10: With bit 28 set, `tx_fsync` equals `fsg`, and `tx_load` has no effect on it.
- R11: A write clears the divider, the frame count and the resync arming. `bclk_en` and `fsg` are 0 in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| ext_clk | input | 1 | External source clock (asynchronous) |
| rx_frame | input | 1 | Receive frame pulse (asynchronous) |
| tx_load | input | 1 | Transmit buffer-to-shift-register load strobe |
| bclk_en | output | 1 | Bit-clock tick, one system cycle wide |
| fsg | output | 1 | Generated frame pulse |
| tx_fsync | output | 1 | Transmit frame pulse |

## Verification
The hardest situation to reach is a resync where a receive frame edge arrives between two bit-clock ticks. From that point on, the frame sequence must diverge from what the programmed period would give. The stimulus first runs the external clock until several ticks have passed with the frame pulse held low. It then stops the external clock and sends a receive frame pulse. Finally it restarts the clock, with a period value chosen so that a free-running frame would wrap on the third tick where a resynced one stays low. The falling-edge mode is told apart from the rising-edge mode by an asymmetric external clock whose high phase shifts the first tick by a known number of cycles.

// File: rtl/smpl_rate_gen.sv
module smpl_rate_gen #(
  parameter logic [31:0] RESET_CFG = 32'h2000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        ext_clk,
  input  logic        rx_frame,
  input  logic        tx_load,
  output logic        bclk_en,
  output logic        fsg,
  output logic        tx_fsync
);
  localparam int DIV_W = 8;
  localparam int POS_W = 12;
  localparam int WID_W = 8;
  localparam int SYNC_N = 3;

  logic [31:0]       cfg_q;
  logic [SYNC_N-1:0] ck_s, rx_s;
  logic [DIV_W-1:0]  div_cnt;
  logic [POS_W-1:0]  pos, pos_nxt;
  logic              armed, clkg_q, fsg_q, xfs_q;

  wire              resync_en = cfg_q[31];
  wire              ext_fall  = cfg_q[30];
  wire              int_src   = cfg_q[29];
  wire              fs_gen    = cfg_q[28];
  wire [POS_W-1:0]  per       = cfg_q[27:16];
  wire [WID_W-1:0]  wid       = cfg_q[15:8];
  wire [DIV_W-1:0]  cdv       = cfg_q[7:0];

  wire ck_rise  = ck_s[1] & ~ck_s[2];
  wire ck_drop  = ~ck_s[1] & ck_s[2];
  wire rx_edge  = rx_s[1] & ~rx_s[2];
  wire sync_md  = ~int_src & resync_en;
  wire src_tick = int_src | (ext_fall ? ck_drop : ck_rise);
  wire div_hit  = src_tick && (div_cnt == cdv);
  wire restart  = sync_md & rx_edge;
  wire fs_gate  = ~sync_md | armed;
  wire in_width = pos <= {{(POS_W-WID_W){1'b0}}, wid};

  always_comb begin
    if (sync_md)
      pos_nxt = (&pos) ? pos : pos + 1'b1;
    else
      pos_nxt = (pos == per) ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      rx_s <= '0;
      xfs_q <= 1'b0;
    end else begin
      ck_s <= {ck_s[SYNC_N-2:0], ext_clk};
      rx_s <= {rx_s[SYNC_N-2:0], rx_frame};
      xfs_q <= tx_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= RESET_CFG;
      div_cnt <= '0;
      pos     <= '0;
      armed   <= 1'b0;
      clkg_q  <= 1'b0;
      fsg_q   <= 1'b0;
    end else if (cfg_we) begin
      cfg_q   <= cfg_wdata;
      div_cnt <= '0;
      pos     <= '0;
      armed   <= 1'b0;
      clkg_q  <= 1'b0;
      fsg_q   <= 1'b0;
    end else begin
      clkg_q <= div_hit & ~restart;
      if (restart) begin
        div_cnt <= '0;
        pos     <= '0;
        armed   <= 1'b1;
      end else if (src_tick) begin
        div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        if (div_hit) begin
          fsg_q <= fs_gate & in_width;
          pos   <= pos_nxt;
        end
      end
    end
  end

  assign bclk_en  = clkg_q;
  assign fsg      = fsg_q;
  assign tx_fsync = fs_gen ? fsg_q : xfs_q;
endmodule

module smpl_rate_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        tx_load,
  input logic        bclk_en,
  input logic        fsg,
  input logic        tx_fsync,
  input logic [31:0] cfg
);
  assert_clkg_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[29] && cfg[7:0] == 8'd0 && !$past(cfg_we)) |-> bclk_en);

  assert_clkg_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[29] && cfg[7:0] != 8'd0 && bclk_en) |=> !bclk_en);

  assert_fsg_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fsg) && !$past(cfg_we)) |-> bclk_en);

  assert_txfs_from_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[28] && !$past(cfg_we)) |-> (tx_fsync == $past(tx_load)));

  assert_write_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> (!bclk_en && !fsg));
endmodule

bind smpl_rate_gen smpl_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tx_load(tx_load),
  .bclk_en(bclk_en), .fsg(fsg), .tx_fsync(tx_fsync), .cfg(cfg_q)
);

// File: tb/smpl_rate_gen_tb.sv
`timescale 1ns/1ps
module smpl_rate_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, ext_clk = 1'b0, rx_frame = 1'b0, tx_load = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic bclk_en, fsg, tx_fsync;

  smpl_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ext_clk(ext_clk), .rx_frame(rx_frame), .tx_load(tx_load),
    .bclk_en(bclk_en), .fsg(fsg), .tx_fsync(tx_fsync)
  );

  always #2 clk = ~clk;

  typedef struct { int gap; bit fs; bit tx; string tag; } item_t;
  item_t exp_q[$];
  item_t e;
  int cyc = 0, last_cyc = 0, n_chk = 0, n_fail = 0, g;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bclk_en) begin
      g = cyc - last_cyc;
      last_cyc = cyc;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_chk++;
        if (!((e.gap < 0 || g == e.gap) && fsg == e.fs && tx_fsync == e.tx)) begin
          n_fail++;
          $display("FAIL %s: tick gap/fsg/tx actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                   e.tag, g, fsg, tx_fsync, e.gap, e.fs, e.tx);
        end
      end
    end
  end

  function automatic logic [31:0] mk(bit rs, bit fall, bit isrc, bit gen, int p, int w, int d);
    return {rs, fall, isrc, gen, p[11:0], w[7:0], d[7:0]};
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    last_cyc = cyc;
  endtask

  task automatic push(input int gap, input bit fs, input bit tx, input string tag);
    item_t it;
    it.gap = gap; it.fs = fs; it.tx = tx; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drain(input int wait_n, input string tag);
    repeat (wait_n) @(negedge clk);
    chk(exp_q.size() == 0, tag, "ticks not seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic ext_run(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1;
      repeat (hi) @(negedge clk);
      ext_clk = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state and defaults
    repeat (4) @(negedge clk);
    chk(bclk_en == 0 && fsg == 0 && tx_fsync == 0, "R1", "outputs in reset",
        {bclk_en, fsg, tx_fsync}, 0);
    rst_n = 1'b1;
    last_cyc = cyc;
    for (int k = 0; k < 3; k++) push(2, 1, 0, "R1");
    drain(10, "R1");

    // R2 R3 R6 R10: internal source, D=2 P=3 W=1, ext_clk toggling is ignored
    wr(mk(0, 0, 1, 1, 3, 1, 2));
    for (int k = 0; k < 8; k++) push(3, (k % 4) <= 1, (k % 4) <= 1, "R3 R6 R10");
    ext_run(5, 2, 3);
    drain(10, "R3");

    // R6 R9: D=0 P=4 W=0, transmit frame from load strobes
    wr(mk(0, 0, 1, 0, 4, 0, 0));
    for (int k = 0; k < 10; k++) push(1, (k % 5) == 0, 0, "R6 R9");
    drain(15, "R6");
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(tx_fsync == 1, "R9", "tx_fsync after load", tx_fsync, 1);
    @(negedge clk);
    chk(tx_fsync == 0, "R9", "tx_fsync one cycle", tx_fsync, 0);

    // R10: generator drives transmit frame, load strobe ignored
    wr(mk(0, 0, 1, 1, 9, 0, 0));
    for (int k = 0; k < 12; k++) push(1, (k % 10) == 0, (k % 10) == 0, "R10");
    @(negedge clk);
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(tx_fsync == 0, "R10", "tx_fsync ignores load", tx_fsync, 0);
    drain(15, "R10");

    // R4 R8: external rising edges, D=1 P=2 W=0, rx_frame pulse ignored
    wr(mk(0, 0, 0, 1, 2, 0, 1));
    for (int k = 0; k < 6; k++) push(k == 0 ? 8 : 10, (k % 3) == 0, (k % 3) == 0, "R4 R8");
    fork
      ext_run(12, 2, 3);
      begin
        repeat (20) @(negedge clk);
        rx_frame = 1'b1;
        repeat (3) @(negedge clk);
        rx_frame = 1'b0;
      end
    join
    drain(6, "R4");

    // R5: external falling edges, D=0 P=0 W=0
    wr(mk(0, 1, 0, 1, 0, 0, 0));
    for (int k = 0; k < 5; k++) push(5, 1, 1, "R5");
    ext_run(5, 2, 3);
    drain(6, "R5");

    // R7: resync to rx_frame, P=2 ignored, W=1, D=1
    wr(mk(1, 0, 0, 1, 2, 1, 1));
    push(7, 0, 0, "R7"); push(8, 0, 0, "R7"); push(8, 0, 0, "R7");
    push(-1, 1, 1, "R7"); push(8, 1, 1, "R7"); push(8, 0, 0, "R7"); push(8, 0, 0, "R7");
    ext_run(6, 2, 2);
    repeat (4) @(negedge clk);
    rx_frame = 1'b1;
    repeat (2) @(negedge clk);
    rx_frame = 1'b0;
    repeat (4) @(negedge clk);
    ext_run(8, 2, 2);
    drain(6, "R7");

    // R11: rewrite mid-count restarts divider and frame
    wr(mk(0, 0, 1, 1, 1, 0, 4));
    push(5, 1, 1, "R11"); push(5, 0, 0, "R11");
    drain(12, "R11");
    wr(mk(0, 0, 1, 1, 1, 0, 4));
    chk(bclk_en == 0 && fsg == 0, "R11", "outputs after write", {bclk_en, fsg}, 0);
    push(5, 1, 1, "R11"); push(5, 0, 0, "R11");
    drain(12, "R11");

    finish_run();
  end
endmodule